// File: doc/BRIEF.md
# ADC Register Front End

This block is the CPU-facing register file of a successive-approximation converter. A small bus with address, write strobe, read strobe and byte-wide data reaches two registers. The control/status register holds a 5-bit channel select, a continuous-run enable, an interrupt enable and a top bit whose meaning depends on the interrupt enable. The data register holds the most recent conversion result.

The block starts the converter core with a one-cycle strobe and presents the selected channel. The core answers with a one-cycle done pulse and a result byte. The block latches that result. It then either sets the completion flag or raises a CPU interrupt request, depending on the interrupt enable.

With interrupts off, the top bit is a read-only completion flag. With interrupts on, it is a writable routing select. No DMA engine is attached, so a set routing select silences the CPU request. Channel code 0x1F means the converter is off, and no conversion is started on it.

Top module: `adc_regfront`

## Requirements
- R1: After reset the control/status register reads 0x1F, the data register reads 0x00, and conv_start and irq_cpu are low.
- R2: The control/status register is at bus address 0x3C. Its read layout is: bit 7 the completion/route flag, bit 6 the interrupt enable, bit 5 the continuous enable, bits 4..0 the channel. A write loads bits 6..0, and conv_chan follows the channel field.
- R3: A write to 0x3C whose channel field is not 0x1F drives conv_start high for exactly the next cycle. A write with channel 0x1F starts nothing.
- R4: On a conv_done cycle, conv_result is captured into the data register, which reads at bus address 0x3D.
- R5: With the interrupt enable at 0, bit 7 ignores written values and becomes 1 after a conv_done.
- R6: With the interrupt enable at 0, bit 7 is cleared by any write to 0x3C or any read of 0x3D. A conv_done in the same cycle as a data read takes precedence, and a control write takes precedence over a conv_done.
- R7: With continuous enable set and channel not 0x1F, each conv_done causes conv_start on the next cycle unless a control write occurs in that cycle. Only the first conv_done after a control write sets bit 7.
- R8: With the interrupt enable at 1, bit 7 takes the written value and keeps it across conv_done pulses and data reads.
- R9: A conv_done with interrupt enable 1 and bit 7 at 0 raises irq_cpu on the next cycle. irq_cpu stays high until a data read or a control write, and a conv_done in the same cycle as a data read keeps it high.
- R10: While interrupt enable and bit 7 are both 1, irq_cpu stays low.
- R11: Addresses other than 0x3C and 0x3D read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| conv_start | output | 1 | One-cycle start strobe to converter core |
| conv_chan | output | 5 | Selected channel |
| conv_done | input | 1 | One-cycle completion pulse from core |
| conv_result | input | 8 | Result byte, valid with conv_done |
| irq_cpu | output | 1 | CPU interrupt request |

## Verification
Each stimulus applied before a clock edge has its effect visible from that edge onward. conv_start, irq_cpu, the flag and the data register all change in the cycle after the write, read or done pulse that triggers them. bus_rdata, by contrast, follows the address combinationally within the same cycle. The bench drives inputs on the falling edge and checks bus_rdata just after driving, against the state before the edge. It checks conv_start, conv_chan and irq_cpu on the next falling edge, against a model advanced once per rising edge. Directed scenarios then read registers back one cycle after the event, so that every check samples at the cycle the requirement sets.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;
   // bit positions inside the control/status byte (decoded by software)
   localparam int unsigned FLAG_BIT = 7;
   localparam int unsigned IEN_BIT  = 6;
   localparam int unsigned CONT_BIT = 5;
   localparam int unsigned CHAN_W   = 5;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_DAT  = 2'd2
   } reg_sel_e;

   typedef struct packed {
      logic              flag;
      logic              ien;
      logic              cont;
      logic [CHAN_W-1:0] chan;
   } ctl_reg_t;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
   import adc_regfront_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    CTL_ADDR = 8'h3C,
   parameter logic [ADDR_W-1:0]    DAT_ADDR = 8'h3D
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output reg_sel_e          sel,
   output logic              ctl_wr,
   output logic              dat_rd
);
   always_comb begin
      if (addr == CTL_ADDR)      sel = SEL_CTL;
      else if (addr == DAT_ADDR) sel = SEL_DAT;
      else                       sel = SEL_NONE;
   end

   assign ctl_wr = wr && (sel == SEL_CTL);
   assign dat_rd = rd && (sel == SEL_DAT);
endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
   import adc_regfront_pkg::*;
#(
   parameter int unsigned BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             dat_rd,
   input  logic [BUS_W-1:0] wdata,
   input  logic             done,
   output ctl_reg_t         ctl
);
   localparam logic [CHAN_W-1:0] CHAN_RST = '1;

   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl.flag <= 1'b0;
         ctl.ien  <= 1'b0;
         ctl.cont <= 1'b0;
         ctl.chan <= CHAN_RST;
         seen_q   <= 1'b0;
      end else if (ctl_wr) begin
         ctl.ien  <= wdata[IEN_BIT];
         ctl.cont <= wdata[CONT_BIT];
         ctl.chan <= wdata[CHAN_W-1:0];
         // writable only when interrupts are being enabled by this write
         ctl.flag <= wdata[IEN_BIT] & wdata[FLAG_BIT];
         seen_q   <= 1'b0;
      end else begin
         if (done) seen_q <= 1'b1;
         if (!ctl.ien) begin
            if (done && (!ctl.cont || !seen_q)) ctl.flag <= 1'b1;
            else if (dat_rd)                    ctl.flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_regfront_pkg::*;
#(
   parameter int unsigned RES_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              dat_rd,
   input  logic [CHAN_W-1:0] wr_chan,
   input  ctl_reg_t          ctl,
   input  logic              done,
   input  logic [RES_W-1:0]  result,
   output logic              start,
   output logic [RES_W-1:0]  data,
   output logic              irq
);
   localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start <= 1'b0;
         data  <= '0;
         irq_q <= 1'b0;
      end else begin
         if (done) data <= result;
         if (ctl_wr) begin
            start <= (wr_chan != CHAN_OFF);
            irq_q <= 1'b0;
         end else begin
            start <= done && ctl.cont && (ctl.chan != CHAN_OFF);
            if (done && ctl.ien && !ctl.flag) irq_q <= 1'b1;
            else if (dat_rd)                  irq_q <= 1'b0;
         end
      end
   end

   // route select set means the request belongs to an absent DMA engine
   assign irq = irq_q & ctl.ien & ~ctl.flag;
endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
   import adc_regfront_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       BUS_W    = 8,
   parameter int unsigned       RES_W    = 8,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h3C,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h3D,
   parameter bit                RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic              irq_cpu
);
   localparam int unsigned CTL_W = $bits(ctl_reg_t);

   if (BUS_W != CTL_W) begin : g_bad_bus_w
      $error("bus width must equal control register width");
   end
   if (RES_W > BUS_W) begin : g_bad_res_w
      $error("result wider than bus");
   end
   if (CTL_ADDR == DAT_ADDR) begin : g_bad_map
      $error("register addresses collide");
   end

   reg_sel_e         sel;
   logic             ctl_wr;
   logic             dat_rd;
   ctl_reg_t         ctl;
   logic [RES_W-1:0] data;
   logic [BUS_W-1:0] rd_mux;

   adc_bus_decode #(
      .ADDR_W  (ADDR_W),
      .CTL_ADDR(CTL_ADDR),
      .DAT_ADDR(DAT_ADDR)
   ) u_dec (
      .addr  (bus_addr),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .sel   (sel),
      .ctl_wr(ctl_wr),
      .dat_rd(dat_rd)
   );

   adc_ctl_reg #(.BUS_W(BUS_W)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl_wr(ctl_wr),
      .dat_rd(dat_rd),
      .wdata (bus_wdata),
      .done  (conv_done),
      .ctl   (ctl)
   );

   adc_conv_seq #(.RES_W(RES_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_wr (ctl_wr),
      .dat_rd (dat_rd),
      .wr_chan(bus_wdata[CHAN_W-1:0]),
      .ctl    (ctl),
      .done   (conv_done),
      .result (conv_result),
      .start  (conv_start),
      .data   (data),
      .irq    (irq_cpu)
   );

   assign conv_chan = ctl.chan;

   always_comb begin
      unique case (sel)
         SEL_CTL: rd_mux = ctl;
         SEL_DAT: rd_mux = BUS_W'(data);
         default: rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      logic [BUS_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end
endmodule

// File: rtl/adc_regfront_chk.sv
module adc_regfront_chk
   import adc_regfront_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       BUS_W    = 8,
   parameter int unsigned       RES_W    = 8,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h3C,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h3D
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              conv_start,
   input logic [CHAN_W-1:0] conv_chan,
   input logic              conv_done,
   input logic [RES_W-1:0]  conv_result,
   input logic              irq_cpu,
   input logic              st_flag,
   input logic              st_ien,
   input logic              st_cont,
   input logic [RES_W-1:0]  st_data
);
   localparam logic [CHAN_W-1:0] OFF = '1;
   logic cw, dr;
   assign cw = bus_wr && (bus_addr == CTL_ADDR);
   assign dr = bus_rd && (bus_addr == DAT_ADDR);

   a_r3_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      cw && (bus_wdata[CHAN_W-1:0] != OFF) |=> conv_start);
   a_r3_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> conv_chan != OFF);
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> st_data == $past(conv_result));
   a_r7_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && st_cont && (conv_chan != OFF) && !cw |=> conv_start);
   a_r9_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      cw |=> !irq_cpu);
   a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      dr && !conv_done |=> !irq_cpu);
   a_r10_route_masks: assert property (@(posedge clk) disable iff (!rst_n)
      st_ien && st_flag |-> !irq_cpu);
   a_r5_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done && !st_ien && !st_cont && !cw |=> st_flag);
endmodule

bind adc_regfront adc_regfront_chk #(
   .ADDR_W  (ADDR_W),
   .BUS_W   (BUS_W),
   .RES_W   (RES_W),
   .CTL_ADDR(CTL_ADDR),
   .DAT_ADDR(DAT_ADDR)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .conv_done  (conv_done),
   .conv_result(conv_result),
   .irq_cpu    (irq_cpu),
   .st_flag    (ctl.flag),
   .st_ien     (ctl.ien),
   .st_cont    (ctl.cont),
   .st_data    (data)
);

// File: tb/adc_regfront_tb.sv
module adc_regfront_tb_top;
   localparam logic [7:0] CTL = 8'h3C;
   localparam logic [7:0] DAT = 8'h3D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       conv_start;
   logic [4:0] conv_chan;
   logic       conv_done = 1'b0;
   logic [7:0] conv_result = '0;
   logic       irq_cpu;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit finished = 0;

   // bench model of architectural state
   logic       m_flag, m_ien, m_cont, m_seen, m_irq, m_start;
   logic [4:0] m_chan;
   logic [7:0] m_data;
   bit         auto_conv = 0;
   int         conv_cnt = 0;

   always #4 clk = ~clk;   // 125 MHz

   adc_regfront dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_result(conv_result), .irq_cpu(irq_cpu)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [7:0] a);
      if (a == CTL) return {m_flag, m_ien, m_cont, m_chan};
      if (a == DAT) return m_data;
      return 8'h00;
   endfunction

   function automatic string read_tag(input logic [7:0] a);
      if (a == CTL) return "R2 R5 R6 R8 readback";
      if (a == DAT) return "R4 data readback";
      return "R11 unmapped read";
   endfunction

   task automatic model_reset();
      m_flag = 0; m_ien = 0; m_cont = 0; m_seen = 0; m_irq = 0; m_start = 0;
      m_chan = 5'h1F; m_data = 8'h00;
   endtask

   task automatic model_edge();
      logic cw, dr;
      cw = bus_wr && bus_addr == CTL;
      dr = bus_rd && bus_addr == DAT;
      if (conv_done) m_data = conv_result;
      if (cw) begin
         m_ien = bus_wdata[6]; m_cont = bus_wdata[5]; m_chan = bus_wdata[4:0];
         m_flag = bus_wdata[6] & bus_wdata[7];
         m_seen = 0; m_irq = 0; m_start = (bus_wdata[4:0] != 5'h1F);
      end else begin
         m_start = conv_done && m_cont && m_chan != 5'h1F;
         if (conv_done && m_ien && !m_flag) m_irq = 1;
         else if (dr) m_irq = 0;
         if (!m_ien) begin
            if (conv_done && (!m_cont || !m_seen)) m_flag = 1;
            else if (dr) m_flag = 0;
         end
         if (conv_done) m_seen = 1;
      end
   endtask

   // one clock: inputs already driven at the falling edge
   task automatic step();
      #1;
      check(bus_rdata, model_read(bus_addr), read_tag(bus_addr));
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check({7'd0, conv_start}, {7'd0, m_start}, "R3 R7 start strobe");
      check({3'd0, conv_chan}, {3'd0, m_chan}, "R2 channel output");
      check({7'd0, irq_cpu}, {7'd0, m_irq & m_ien & ~m_flag}, "R9 R10 irq");
      bus_wr = 0; bus_rd = 0;
      conv_done = 0;
      if (auto_conv) begin
         if (conv_start) conv_cnt = 2 + int'($urandom % 4);
         else if (conv_cnt > 0) begin
            conv_cnt--;
            if (conv_cnt == 0) begin
               conv_done = 1; conv_result = 8'($urandom);
            end
         end
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1; step();
   endtask

   task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a; bus_rd = 1;
      #1 check(bus_rdata, exp, tag);
      step();
   endtask

   task automatic done_pulse(input logic [7:0] r);
      conv_done = 1; conv_result = r; bus_addr = 8'h00; step();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0ADC));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check({7'd0, conv_start}, 8'd0, "R1 start low after reset");
      check({7'd0, irq_cpu}, 8'd0, "R1 irq low after reset");
      rd_expect(CTL, 8'h1F, "R1 control reset value");
      rd_expect(DAT, 8'h00, "R1 data reset value");

      // flag ignored on write with interrupts off; start strobe
      wr(CTL, 8'h83);
      check({7'd0, conv_start}, 8'd1, "R3 start after write");
      check({3'd0, conv_chan}, 8'h03, "R2 channel follows write");
      rd_expect(CTL, 8'h03, "R5 flag write ignored");
      check({7'd0, conv_start}, 8'd0, "R3 strobe lasts one cycle");
      done_pulse(8'hA5);
      rd_expect(CTL, 8'h83, "R5 flag set by done");
      rd_expect(DAT, 8'hA5, "R4 result captured");
      rd_expect(CTL, 8'h03, "R6 flag cleared by data read");
      done_pulse(8'h3C);
      wr(CTL, 8'h1F);
      check({7'd0, conv_start}, 8'd0, "R3 no start on channel 0x1F");
      rd_expect(CTL, 8'h1F, "R6 flag cleared by control write");
      // done beats a simultaneous data read
      wr(CTL, 8'h04);
      conv_done = 1; conv_result = 8'h11; bus_addr = DAT; bus_rd = 1; step();
      rd_expect(CTL, 8'h84, "R6 done wins over data read");

      // continuous mode
      wr(CTL, 8'h25);
      done_pulse(8'h01);
      check({7'd0, conv_start}, 8'd1, "R7 auto restart");
      rd_expect(DAT, 8'h01, "R4 continuous capture");
      rd_expect(CTL, 8'h25, "R7 flag cleared by read");
      done_pulse(8'h02);
      check({7'd0, conv_start}, 8'd1, "R7 second restart");
      rd_expect(CTL, 8'h25, "R7 flag not set after first");

      // interrupt path
      wr(CTL, 8'h42);
      done_pulse(8'h77);
      check({7'd0, irq_cpu}, 8'd1, "R9 irq raised");
      rd_expect(DAT, 8'h77, "R4 data with irq");
      check({7'd0, irq_cpu}, 8'd0, "R9 irq cleared by read");
      done_pulse(8'h78);
      check({7'd0, irq_cpu}, 8'd1, "R9 irq raised again");
      wr(CTL, 8'h42);
      check({7'd0, irq_cpu}, 8'd0, "R9 irq cleared by write");
      wr(CTL, 8'hC2);
      rd_expect(CTL, 8'hC2, "R8 route bit written");
      done_pulse(8'h79);
      check({7'd0, irq_cpu}, 8'd0, "R10 irq masked by route bit");
      rd_expect(DAT, 8'h79, "R4 data under route bit");
      rd_expect(CTL, 8'hC2, "R8 route bit kept");

      // unmapped access
      wr(8'h3E, 8'hFF);
      check({7'd0, conv_start}, 8'd0, "R11 unmapped write no start");
      rd_expect(CTL, 8'hC2, "R11 unmapped write no effect");
      rd_expect(8'h3E, 8'h00, "R11 unmapped read zero");

      // constrained random phase with a converter model
      auto_conv = 1;
      for (int i = 0; i < 4000; i++) begin
         int sel;
         sel = int'($urandom % 100);
         if (sel < 12) begin
            bus_addr = CTL; bus_wr = 1;
            bus_wdata = 8'($urandom);
            if (($urandom % 8) == 0) bus_wdata[4:0] = 5'h1F;
         end else if (sel < 30) begin
            bus_addr = DAT; bus_rd = 1;
         end else if (sel < 40) begin
            bus_addr = CTL; bus_rd = 1;
         end else if (sel < 44) begin
            bus_addr = 8'($urandom); bus_wr = 1; bus_wdata = 8'($urandom);
            if (bus_addr == CTL || bus_addr == DAT) bus_wr = 0;
         end else begin
            bus_addr = 8'($urandom);
         end
         step();
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule